// File: doc/BRIEF.md
# Reordering Bus Request Scheduler with Castout Priority

This block sits between a core's load/store pipeline and the system bus. Ordinary memory requests (loads and stores) enter a small age-ordered queue. Castouts of modified lines that snooping has forced out enter a second queue of their own. Each cycle the block offers exactly one request on a single issue port. The bus accepts it with a ready handshake.

Castouts always win, so they are never stuck behind traffic that arrived before them. Among ordinary requests, loads are preferred and may overtake stores that are older. A load may not overtake an older store that touches the same 32-byte cache line. Stores leave strictly in program order. A store is sent only when there is no castout and no load that may go.

Top module: `bus_req_sched`

## Requirements
- R1: After reset both queues are empty, `iss_valid` is low, and `ls_full` and `sp_full` are low.
- R2: The load/store queue holds 4 entries and `ls_full` is high exactly while it holds 4. An enqueue offered while `ls_full` is high is dropped, even if an entry leaves in the same cycle.
- R3: The castout queue holds 2 entries and `sp_full` is high exactly while it holds 2. An enqueue offered while `sp_full` is high is dropped.
- R4: While the castout queue is not empty, the issue port presents its head, ahead of every queued load or store regardless of age.
- R5: Castouts are issued in arrival order.
- R6: A load is presented ahead of older stores when none of those stores falls in its 32-byte line (address bits above bit 4 differ).
- R7: A load is held back while any older queued store has equal address bits above bit 4. That store is presented first.
- R8: Among loads that may go, the oldest one is presented.
- R9: Stores are presented in the order they were enqueued.
- R10: A store is presented only when the castout queue is empty and no load may go. Then the oldest store is presented.
- R11: A request leaves its queue only at a clock edge where `iss_valid` and `iss_ready` are both high. With `iss_ready` low, the presented request stays until a newer enqueue outranks it.
- R12: `iss_kind` encodes load as 0, store as 1 and castout as 2. `iss_addr` and `iss_id` carry the address and tag that were given at enqueue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_valid | input | 1 | Enqueue a load or store |
| ls_is_store | input | 1 | 1 = store, 0 = load |
| ls_addr | input | 32 | Byte address of the request |
| ls_id | input | 4 | Tag returned with the issue |
| ls_full | output | 1 | Load/store queue holds 4 entries |
| sp_valid | input | 1 | Enqueue a castout |
| sp_addr | input | 32 | Castout address |
| sp_id | input | 4 | Castout tag |
| sp_full | output | 1 | Castout queue holds 2 entries |
| iss_valid | output | 1 | A request is presented |
| iss_ready | input | 1 | Bus takes the presented request this cycle |
| iss_kind | output | 2 | 0 load, 1 store, 2 castout |
| iss_addr | output | 32 | Address of the presented request |
| iss_id | output | 4 | Tag of the presented request |

## Verification
Directed sequences set up four patterns. In the first, a load trails a store in a different line, which shows real bypass apart from plain FIFO order. In the second, the load trails a store in the same line but at a different byte offset, which shows line-level matching apart from exact-address matching. In the third, a castout arrives behind a full load/store queue, which shows that castouts take priority. In the fourth, `iss_ready` is held low, which shows that the handshake decides when an entry leaves. Random traffic then mixes loads, stores and castouts over four lines with ready toggling at random. This reaches overflow, simultaneous enqueue and issue, and chains of blocked loads, all compared against a queue model.

// File: rtl/brq_pkg.sv
package brq_pkg;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 4;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_PUSH  = 2'd2
    } kind_e;

    typedef struct packed {
        logic              st;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
    } ls_ent_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
    } sp_ent_t;
endpackage

// File: rtl/brq_ls_queue.sv
module brq_ls_queue
    import brq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enq_en,
    input  ls_ent_t                enq_ent,
    input  logic                   rm_en,
    input  logic [IDX_W-1:0]       rm_idx,
    output ls_ent_t [DEPTH-1:0]    ents,
    output logic    [DEPTH-1:0]    vld,
    output logic                   full
);
    typedef struct packed {
        ls_ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]    cnt;
    } state_t;

    state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_mid;

    assign full = (st_q.cnt == CNT_W'(DEPTH));
    assign ents = st_q.ent;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) vld[i] = (CNT_W'(i) < st_q.cnt);
    end

    always_comb begin
        st_d    = st_q;
        cnt_mid = st_q.cnt;
        if (rm_en) begin
            for (int i = 0; i < DEPTH - 1; i++)
                if (i >= int'(rm_idx)) st_d.ent[i] = st_q.ent[i+1];
            cnt_mid = st_q.cnt - CNT_W'(1);
        end
        st_d.cnt = cnt_mid;
        if (enq_en && !full) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_mid) st_d.ent[i] = enq_ent;
            st_d.cnt = cnt_mid + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LSQ_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));  // R2
    AST_LSQ_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && !rm_en |=> st_q.cnt == CNT_W'(DEPTH));  // R2
    AST_LSQ_RM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> vld[rm_idx]);  // R11
endmodule

// File: rtl/brq_push_fifo.sv
module brq_push_fifo
    import brq_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enq_en,
    input  sp_ent_t enq_ent,
    input  logic    pop_en,
    output sp_ent_t head,
    output logic    nonempty,
    output logic    full
);
    typedef struct packed {
        sp_ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]    cnt;
    } state_t;

    state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_mid;

    assign full     = (st_q.cnt == CNT_W'(DEPTH));
    assign nonempty = (st_q.cnt != '0);
    assign head     = st_q.ent[0];

    always_comb begin
        st_d    = st_q;
        cnt_mid = st_q.cnt;
        if (pop_en) begin
            for (int i = 0; i < DEPTH - 1; i++) st_d.ent[i] = st_q.ent[i+1];
            cnt_mid = st_q.cnt - CNT_W'(1);
        end
        st_d.cnt = cnt_mid;
        if (enq_en && !full) begin
            for (int i = 0; i < DEPTH; i++)
                if (CNT_W'(i) == cnt_mid) st_d.ent[i] = enq_ent;
            st_d.cnt = cnt_mid + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_SPQ_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));  // R3
    AST_SPQ_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> nonempty);  // R11
endmodule

// File: rtl/brq_pick.sv
module brq_pick
    import brq_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int LINE_BYTES = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int OFF_W = $clog2(LINE_BYTES)
) (
    input  ls_ent_t [DEPTH-1:0] ents,
    input  logic    [DEPTH-1:0] vld,
    output logic                ld_ok,
    output logic [IDX_W-1:0]    ld_idx,
    output logic                st_ok,
    output logic [IDX_W-1:0]    st_idx
);
    logic [DEPTH-1:0] blocked;
    logic [DEPTH-1:0] is_st;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_kind
            assign is_st[g] = vld[g] && ents[g].st;
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++)
                if (j < i && is_st[j] &&
                    ents[j].addr[ADDR_W-1:OFF_W] == ents[i].addr[ADDR_W-1:OFF_W])
                    blocked[i] = 1'b1;
        end
    end

    always_comb begin
        ld_ok  = 1'b0;
        ld_idx = '0;
        st_ok  = 1'b0;
        st_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && !ents[i].st && !blocked[i]) begin
                ld_ok  = 1'b1;
                ld_idx = IDX_W'(i);
            end
            if (is_st[i]) begin
                st_ok  = 1'b1;
                st_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/bus_req_sched.sv
module bus_req_sched
    import brq_pkg::*;
#(
    parameter int LS_DEPTH   = 4,
    parameter int SP_DEPTH   = 2,
    parameter int LINE_BYTES = 32,
    localparam int IDX_W = $clog2(LS_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ls_valid,
    input  logic              ls_is_store,
    input  logic [ADDR_W-1:0] ls_addr,
    input  logic [ID_W-1:0]   ls_id,
    output logic              ls_full,
    input  logic              sp_valid,
    input  logic [ADDR_W-1:0] sp_addr,
    input  logic [ID_W-1:0]   sp_id,
    output logic              sp_full,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [1:0]        iss_kind,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [ID_W-1:0]   iss_id
);
    ls_ent_t [LS_DEPTH-1:0] ls_ents;
    logic    [LS_DEPTH-1:0] ls_vld;
    sp_ent_t                sp_head;
    logic                   sp_nonempty;
    logic                   ld_ok, st_ok;
    logic [IDX_W-1:0]       ld_idx, st_idx;
    logic                   ls_rm, sp_pop;
    logic [IDX_W-1:0]       ls_rm_idx;
    kind_e                  kind;
    ls_ent_t                ls_enq;
    sp_ent_t                sp_enq;

    assign ls_enq = '{st: ls_is_store, addr: ls_addr, id: ls_id};
    assign sp_enq = '{addr: sp_addr, id: sp_id};

    brq_ls_queue #(.DEPTH(LS_DEPTH)) u_lsq (
        .clk(clk), .rst_n(rst_n),
        .enq_en(ls_valid), .enq_ent(ls_enq),
        .rm_en(ls_rm), .rm_idx(ls_rm_idx),
        .ents(ls_ents), .vld(ls_vld), .full(ls_full)
    );

    brq_push_fifo #(.DEPTH(SP_DEPTH)) u_spq (
        .clk(clk), .rst_n(rst_n),
        .enq_en(sp_valid), .enq_ent(sp_enq),
        .pop_en(sp_pop),
        .head(sp_head), .nonempty(sp_nonempty), .full(sp_full)
    );

    brq_pick #(.DEPTH(LS_DEPTH), .LINE_BYTES(LINE_BYTES)) u_pick (
        .ents(ls_ents), .vld(ls_vld),
        .ld_ok(ld_ok), .ld_idx(ld_idx),
        .st_ok(st_ok), .st_idx(st_idx)
    );

    always_comb begin
        iss_valid = 1'b1;
        kind      = KIND_LOAD;
        iss_addr  = '0;
        iss_id    = '0;
        ls_rm_idx = '0;
        if (sp_nonempty) begin
            kind     = KIND_PUSH;
            iss_addr = sp_head.addr;
            iss_id   = sp_head.id;
        end else if (ld_ok) begin
            kind      = KIND_LOAD;
            ls_rm_idx = ld_idx;
        end else if (st_ok) begin
            kind      = KIND_STORE;
            ls_rm_idx = st_idx;
        end else begin
            iss_valid = 1'b0;
        end
        if (kind != KIND_PUSH) begin
            iss_addr = ls_ents[ls_rm_idx].addr;
            iss_id   = ls_ents[ls_rm_idx].id;
        end
    end

    assign iss_kind = kind;
    assign sp_pop   = iss_valid && iss_ready && (kind == KIND_PUSH);
    assign ls_rm    = iss_valid && iss_ready && (kind != KIND_PUSH);

    AST_PUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        sp_nonempty |-> iss_valid && iss_kind == 2'd2);  // R4
    AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready && !ls_valid && !sp_valid
        |=> iss_valid && $stable(iss_addr) && $stable(iss_id) && $stable(iss_kind));  // R11
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !sp_nonempty && ls_vld == '0);  // R10
endmodule

// File: tb/bus_req_sched_test.sv
module bus_req_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ls_valid = 1'b0, ls_is_store = 1'b0;
    logic [31:0] ls_addr = '0;
    logic [3:0]  ls_id = '0;
    logic        sp_valid = 1'b0;
    logic [31:0] sp_addr = '0;
    logic [3:0]  sp_id = '0;
    logic        iss_ready = 1'b0;
    logic        ls_full, sp_full, iss_valid;
    logic [1:0]  iss_kind;
    logic [31:0] iss_addr;
    logic [3:0]  iss_id;

    bus_req_sched uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    string tag = "R1";

    // reference queues
    bit          m_st[4];
    logic [31:0] m_la[4];
    logic [3:0]  m_li[4];
    int          m_ln = 0;
    logic [31:0] m_sa[2];
    logic [3:0]  m_si[2];
    int          m_sn = 0;

    function automatic void ref_pick(output bit v, output int k, output int idx);
        v = 1'b0; k = 0; idx = 0;
        if (m_sn > 0) begin v = 1; k = 2; return; end
        for (int i = 0; i < m_ln; i++) begin
            bit blk = 1'b0;
            if (m_st[i]) continue;
            for (int j = 0; j < i; j++)
                if (m_st[j] && (m_la[j] >> 5) == (m_la[i] >> 5)) blk = 1'b1;
            if (!blk) begin v = 1; k = 0; idx = i; return; end
        end
        for (int i = 0; i < m_ln; i++)
            if (m_st[i]) begin v = 1; k = 1; idx = i; return; end
    endfunction

    task automatic chk(string t, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic compare();
        bit v; int k, idx;
        ref_pick(v, k, idx);
        chk(tag, 64'(iss_valid), 64'(v), "iss_valid");
        if (v) begin
            chk(tag, 64'(iss_kind), 64'(k), "iss_kind");
            chk(tag, 64'(iss_addr), 64'(k == 2 ? m_sa[0] : m_la[idx]), "iss_addr");
            chk(tag, 64'(iss_id),   64'(k == 2 ? m_si[0] : m_li[idx]), "iss_id");
        end
        chk("R2", 64'(ls_full), 64'(m_ln == 4), "ls_full");
        chk("R3", 64'(sp_full), 64'(m_sn == 2), "sp_full");
    endtask

    task automatic cyc(bit lv, bit lst, logic [31:0] la, logic [3:0] li,
                       bit sv, logic [31:0] sa, logic [3:0] si, bit rdy);
        bit v; int k, idx;
        bit lfull, sfull;
        @(negedge clk);
        ls_valid = lv; ls_is_store = lst; ls_addr = la; ls_id = li;
        sp_valid = sv; sp_addr = sa; sp_id = si; iss_ready = rdy;
        #1;
        compare();
        ref_pick(v, k, idx);
        lfull = (m_ln == 4); sfull = (m_sn == 2);
        @(posedge clk);
        if (v && rdy) begin
            if (k == 2) begin
                m_sa[0] = m_sa[1]; m_si[0] = m_si[1]; m_sn--;
            end else begin
                for (int i = idx; i < 3; i++) begin
                    m_st[i] = m_st[i+1]; m_la[i] = m_la[i+1]; m_li[i] = m_li[i+1];
                end
                m_ln--;
            end
        end
        if (lv && !lfull) begin
            m_st[m_ln] = lst; m_la[m_ln] = la; m_li[m_ln] = li; m_ln++;
        end
        if (sv && !sfull) begin
            m_sa[m_sn] = sa; m_si[m_sn] = si; m_sn++;
        end
    endtask

    task automatic enq_ls(bit st, logic [31:0] a, logic [3:0] id);
        cyc(1, st, a, id, 0, 0, 0, 0);
    endtask
    task automatic enq_sp(logic [31:0] a, logic [3:0] id);
        cyc(0, 0, 0, 0, 1, a, id, 0);
    endtask
    task automatic drain();
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        cyc(0, 0, 0, 0, 0, 0, 0, 0);

        // R6: load bypasses older store in another line
        tag = "R6";
        enq_ls(1, 32'h0000_0100, 4'h1);
        enq_ls(0, 32'h0000_0200, 4'h2);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        drain();

        // R7: same line, different offset -> store first
        tag = "R7";
        enq_ls(1, 32'h0000_0304, 4'h3);
        enq_ls(0, 32'h0000_031c, 4'h4);
        drain();

        // R8: oldest eligible load wins; blocked load skipped
        tag = "R8";
        enq_ls(1, 32'h0000_0400, 4'h5);
        enq_ls(0, 32'h0000_0410, 4'h6);
        enq_ls(0, 32'h0000_0500, 4'h7);
        enq_ls(0, 32'h0000_0600, 4'h8);
        drain();

        // R9 / R10: stores only, in order, after all eligible loads
        tag = "R9";
        enq_ls(1, 32'h0000_0700, 4'h9);
        enq_ls(1, 32'h0000_0800, 4'ha);
        enq_ls(1, 32'h0000_0900, 4'hb);
        drain();
        tag = "R10";
        enq_ls(1, 32'h0000_0a00, 4'hc);
        enq_ls(0, 32'h0000_0a08, 4'hd);
        enq_ls(1, 32'h0000_0b00, 4'he);
        drain();

        // R2: overflow of load/store queue is dropped
        tag = "R2";
        for (int i = 0; i < 6; i++) enq_ls(0, 32'h1000 + 32'(i) * 32'h40, 4'(i));
        drain();

        // R3 / R5: castout queue overflow and order
        tag = "R5";
        enq_sp(32'h0000_2000, 4'h1);
        enq_sp(32'h0000_2100, 4'h2);
        tag = "R3";
        enq_sp(32'h0000_2200, 4'h3);
        drain();

        // R4: castout overtakes full load/store queue
        tag = "R4";
        for (int i = 0; i < 4; i++) enq_ls(i[0], 32'h3000 + 32'(i) * 32'h20, 4'(i));
        enq_sp(32'h0000_4000, 4'hf);
        drain();

        // R11: no removal without ready
        tag = "R11";
        enq_ls(0, 32'h0000_5000, 4'h2);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
        drain();

        // R12: random mixed traffic
        tag = "R12";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a = {25'($urandom % 4) << 5, 7'd0} | 32'($urandom % 32);
            cyc(($urandom % 3) != 0, $urandom % 2, a, 4'($urandom),
                ($urandom % 8) == 0, 32'($urandom), 4'($urandom),
                ($urandom % 3) != 0);
        end
        drain();

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule